// File: doc/BRIEF.md
# USB Full-Speed Frame Timer

This block keeps frame time for a full-speed USB host. A bit-time enable from the clocking logic drives a down-counter, which holds the bit times left in the current 1 ms frame. When the counter has reached zero, the next enable reloads it from a programmable interval and advances a 16-bit frame number. The same enable raises a one-cycle start-of-frame pulse. A second event pulse fires each time the top bit of the frame number changes. The interrupt logic uses that pulse to extend the frame number past 16 bits.

Software programs four fields through a small register port: the frame interval with its toggle flag, the full-speed maximum packet size, a periodic start point and a low-speed threshold. The live remaining count, with its own toggle, and the frame number can be read but not written. A change to the interval never disturbs the frame in progress. It is picked up at the next reload, and the toggle copied into the remaining-time view shows software when the new value took hold. A comparator flags the tail of each frame, where periodic traffic may be scheduled.

Top module: `frame_timer`

## Requirements
- R1: After reset the remaining count equals 11999, both toggles are 0, the frame number is 0, and sofPulse and ovfPulse are low. The interval register reads 11999 in bits 13:0, 0x2778 in bits 30:16 and 0 in bit 31.
- R2: Each cycle with bitTick high and a nonzero remaining count lowers the count by exactly one. With bitTick low, the remaining count and the frame number hold.
- R3: A bitTick while the remaining count is zero reloads the count from the interval field and adds one to the frame number. It also drives sofPulse high for exactly the following cycle.
- R4: At each reload the interval toggle (bit 31 of address 0) is copied into the remaining-time toggle (bit 31 of address 1).
- R5: A write to the interval register leaves the current remaining count unchanged. The new interval takes effect at the next reload.
- R6: ovfPulse goes high for one cycle, together with sofPulse, exactly when bit 15 of the frame number changes (0x7FFF to 0x8000 and 0xFFFF to 0x0000). It stays low on every other increment.
- R7: periodicWin is high exactly when the remaining count is less than or equal to the periodic start value.
- R8: Register map on the 3-bit address: 0 interval, 1 remaining (count in 13:0, toggle in 31), 2 frame number (15:0), 3 periodic start (13:0), 4 low-speed threshold (14:0). Addresses 5 to 7 read zero. Writes to addresses 1 and 2 change nothing.
- R9: The writable fields keep only their implemented bits: interval 13:0 and 31, packet size 30:16, periodic start 13:0, threshold 14:0. All other bits read back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitTick | input | 1 | One-cycle enable per USB bit time |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 32 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 32 | Register read data (combinational) |
| sofPulse | output | 1 | Start-of-frame event, one cycle |
| ovfPulse | output | 1 | Frame-number top-bit change event, one cycle |
| periodicWin | output | 1 | Remaining count at or below periodic start |
| frameNum | output | 16 | Current frame number |

## Verification
The embedded properties check several rules on every cycle: the single-step decrement, the hold when no strobe is present, the reload value, the toggle copy and frame increment on each start of frame, the bit-15 change behind every overflow pulse, and the stability of the interval between writes. Other behaviour only the directed scenarios can show. These cover the reset register values, the masking of write data, the ignored writes to read-only addresses, the periodic window moving as the threshold is reprogrammed, and the deferral of a new interval to the next frame. The bench also walks the frame number through both bit-15 transitions and counts that no spurious overflow appears between them.

// File: rtl/frame_timer_pkg.sv
package frame_timer_pkg;
  typedef struct packed {
    logic decStb;
    logic reloadStb;
  } ftStrobe_t;

  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] ADDR_INTERVAL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_REMAIN   = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_FRAMENUM = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_PSTART   = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_LSTHR    = 3'd4;

  localparam int TOG_BIT = 31;
  localparam int MPS_LSB = 16;
endpackage

// File: rtl/frame_timer_ctrl.sv
module frame_timer_ctrl
  import frame_timer_pkg::*;
#(
  parameter int FI_W    = 14,
  parameter int MPS_W   = 15,
  parameter int LST_W   = 15,
  parameter int FN_W    = 16,
  parameter int FI_RST  = 11999,
  parameter int MPS_RST = 16'h2778,
  parameter int PS_RST  = 10799,
  parameter int LST_RST = 16'h0628
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              atZero,
  input  logic [FI_W-1:0]   remCount,
  input  logic              remTog,
  input  logic [FN_W-1:0]   frameNum,
  output ftStrobe_t         stb,
  output logic [FI_W-1:0]   fiVal,
  output logic              fiTog,
  output logic [FI_W-1:0]   psVal
);
  logic [MPS_W-1:0] mpsVal;
  logic [LST_W-1:0] lstVal;
  logic wrIntv, wrPs, wrLst;

  assign wrIntv = wrEn && (wrAddr == ADDR_INTERVAL);
  assign wrPs   = wrEn && (wrAddr == ADDR_PSTART);
  assign wrLst  = wrEn && (wrAddr == ADDR_LSTHR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fiVal  <= FI_W'(FI_RST);
      fiTog  <= 1'b0;
      mpsVal <= MPS_W'(MPS_RST);
      psVal  <= FI_W'(PS_RST);
      lstVal <= LST_W'(LST_RST);
    end else begin
      if (wrIntv) begin
        fiVal  <= wrData[FI_W-1:0];
        mpsVal <= wrData[MPS_LSB +: MPS_W];
        fiTog  <= wrData[TOG_BIT];
      end
      if (wrPs)  psVal  <= wrData[FI_W-1:0];
      if (wrLst) lstVal <= wrData[LST_W-1:0];
    end
  end

  // Terminal count turns a bit tick into a reload instead of a step
  always_comb begin
    stb.decStb    = bitTick && !atZero;
    stb.reloadStb = bitTick && atZero;
  end

  always_comb begin
    rdData = '0;
    case (rdAddr)
      ADDR_INTERVAL: begin
        rdData[FI_W-1:0]         = fiVal;
        rdData[MPS_LSB +: MPS_W] = mpsVal;
        rdData[TOG_BIT]          = fiTog;
      end
      ADDR_REMAIN: begin
        rdData[FI_W-1:0] = remCount;
        rdData[TOG_BIT]  = remTog;
      end
      ADDR_FRAMENUM: rdData[FN_W-1:0]  = frameNum;
      ADDR_PSTART:   rdData[FI_W-1:0]  = psVal;
      ADDR_LSTHR:    rdData[LST_W-1:0] = lstVal;
      default:       rdData = '0;
    endcase
  end

  AST_INTERVAL_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && (wrAddr == ADDR_INTERVAL)) |=> ($stable(fiVal) && $stable(fiTog))); // R5
  AST_PSTART_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && (wrAddr == ADDR_PSTART)) |=> $stable(psVal)); // R8
endmodule

// File: rtl/frame_timer_dp.sv
module frame_timer_dp
  import frame_timer_pkg::*;
#(
  parameter int FI_W   = 14,
  parameter int FN_W   = 16,
  parameter int FI_RST = 11999
) (
  input  logic            clk,
  input  logic            rstN,
  input  ftStrobe_t       stb,
  input  logic [FI_W-1:0] fiVal,
  input  logic            fiTog,
  input  logic [FI_W-1:0] psVal,
  output logic [FI_W-1:0] remCount,
  output logic            remTog,
  output logic [FN_W-1:0] frameNum,
  output logic            atZero,
  output logic            sofPulse,
  output logic            ovfPulse,
  output logic            periodicWin
);
  localparam logic [FI_W-1:0] FI_ONE = {{(FI_W-1){1'b0}}, 1'b1};
  localparam logic [FN_W-1:0] FN_ONE = {{(FN_W-1){1'b0}}, 1'b1};

  logic [FN_W-1:0] fnNext;

  assign fnNext      = frameNum + FN_ONE;
  assign atZero      = (remCount == '0);
  assign periodicWin = (remCount <= psVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remCount <= FI_W'(FI_RST);
      remTog   <= 1'b0;
      frameNum <= '0;
      sofPulse <= 1'b0;
      ovfPulse <= 1'b0;
    end else begin
      sofPulse <= 1'b0;
      ovfPulse <= 1'b0;
      if (stb.reloadStb) begin
        remCount <= fiVal;
        remTog   <= fiTog;
        frameNum <= fnNext;
        sofPulse <= 1'b1;
        ovfPulse <= fnNext[FN_W-1] ^ frameNum[FN_W-1];
      end else if (stb.decStb) begin
        remCount <= remCount - FI_ONE;
      end
    end
  end

  AST_DEC_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
    stb.decStb |=> (remCount == ($past(remCount) - FI_ONE))); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.decStb || stb.reloadStb) |=> ($stable(remCount) && $stable(frameNum))); // R2
  AST_SOF_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    sofPulse |-> ((remCount == $past(fiVal)) && (frameNum == $past(frameNum) + FN_ONE))); // R3
  AST_TOGGLE_COPY: assert property (@(posedge clk) disable iff (!rstN)
    sofPulse |-> (remTog == $past(fiTog))); // R4
  AST_OVF_TOPBIT: assert property (@(posedge clk) disable iff (!rstN)
    ovfPulse |-> (sofPulse && (frameNum[FN_W-1] != $past(frameNum[FN_W-1])))); // R6
endmodule

// File: rtl/frame_timer.sv
module frame_timer
  import frame_timer_pkg::*;
#(
  parameter int FI_W    = 14,
  parameter int MPS_W   = 15,
  parameter int LST_W   = 15,
  parameter int FN_W    = 16,
  parameter int FI_RST  = 11999,
  parameter int MPS_RST = 16'h2778,
  parameter int PS_RST  = 10799,
  parameter int LST_RST = 16'h0628
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              sofPulse,
  output logic              ovfPulse,
  output logic              periodicWin,
  output logic [FN_W-1:0]   frameNum
);
  ftStrobe_t       stb;
  logic [FI_W-1:0] fiVal, psVal, remCount;
  logic            fiTog, remTog, atZero;

  frame_timer_ctrl #(
    .FI_W(FI_W), .MPS_W(MPS_W), .LST_W(LST_W), .FN_W(FN_W),
    .FI_RST(FI_RST), .MPS_RST(MPS_RST), .PS_RST(PS_RST), .LST_RST(LST_RST)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .bitTick(bitTick),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .atZero(atZero), .remCount(remCount), .remTog(remTog), .frameNum(frameNum),
    .stb(stb), .fiVal(fiVal), .fiTog(fiTog), .psVal(psVal)
  );

  frame_timer_dp #(
    .FI_W(FI_W), .FN_W(FN_W), .FI_RST(FI_RST)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .fiVal(fiVal), .fiTog(fiTog), .psVal(psVal),
    .remCount(remCount), .remTog(remTog), .frameNum(frameNum),
    .atZero(atZero), .sofPulse(sofPulse), .ovfPulse(ovfPulse),
    .periodicWin(periodicWin)
  );
endmodule

// File: tb/frame_timer_tb.sv
`timescale 1ns/1ps
module frame_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bitTick = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        sofPulse, ovfPulse, periodicWin;
  logic [15:0] frameNum;

  int nChecks = 0;
  int nFail = 0;
  int sofCnt = 0;
  int ovfCnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  frame_timer u_dut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData),
    .sofPulse(sofPulse), .ovfPulse(ovfPulse),
    .periodicWin(periodicWin), .frameNum(frameNum)
  );

  task automatic check(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, got, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(posedge clk); @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    rdAddr = a;
    #0.5;
    d = rdData;
  endtask

  task automatic runTicks(input int n);
    for (int i = 0; i < n; i++) begin
      bitTick = 1'b1;
      @(posedge clk); @(negedge clk);
      sofCnt += int'(sofPulse);
      ovfCnt += int'(ovfPulse);
    end
    bitTick = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] v;
    regRead(3'd0, v); check("R1", "interval reset", v, 32'h2778_2EDF);
    regRead(3'd1, v); check("R1", "remaining reset", v, 32'd11999);
    check("R1", "frame number reset", {16'h0, frameNum}, 32'h0);
    check("R1", "sof/ovf low", {30'h0, sofPulse, ovfPulse}, 32'h0);
  endtask

  task automatic testCountDown();
    logic [31:0] v;
    runTicks(5);
    regRead(3'd1, v); check("R2", "after 5 ticks", v, 32'd11994);
    repeat (3) @(negedge clk);
    regRead(3'd1, v); check("R2", "idle hold", v, 32'd11994);
    check("R2", "frame idle hold", {16'h0, frameNum}, 32'h0);
  endtask

  task automatic testWindow();
    check("R7", "win off at reset ps", {31'h0, periodicWin}, 32'h0);
    regWrite(3'd3, 32'd11990);
    check("R7", "win off above ps", {31'h0, periodicWin}, 32'h0);
    runTicks(4);
    check("R7", "win on at equal", {31'h0, periodicWin}, 32'h1);
    runTicks(1);
    check("R7", "win on below", {31'h0, periodicWin}, 32'h1);
    regWrite(3'd3, 32'd11988);
    check("R7", "win off after ps lowered", {31'h0, periodicWin}, 32'h0);
  endtask

  task automatic testDeferredInterval();
    logic [31:0] v;
    regWrite(3'd0, 32'h9234_0014);
    regRead(3'd0, v); check("R9", "interval readback", v, 32'h9234_0014);
    regRead(3'd1, v); check("R5", "remaining untouched by write", v, 32'd11989);
    sofCnt = 0;
    runTicks(11989);
    regRead(3'd1, v); check("R2", "count reached zero", v, 32'd0);
    check("R3", "no sof before terminal", sofCnt, 32'd0);
    runTicks(1);
    check("R3", "sof pulse at reload", {31'h0, sofPulse}, 32'h1);
    check("R3", "frame number advanced", {16'h0, frameNum}, 32'h1);
    regRead(3'd1, v); check("R4", "reload value and toggle", v, 32'h8000_0014);
    @(negedge clk);
    check("R3", "sof one cycle wide", {31'h0, sofPulse}, 32'h0);
  endtask

  task automatic testToggleClear();
    logic [31:0] v;
    regWrite(3'd0, 32'h0000_0003);
    runTicks(20);
    regRead(3'd1, v); check("R5", "old frame ran to zero", v, 32'h8000_0000);
    runTicks(1);
    regRead(3'd1, v); check("R4", "toggle cleared at reload", v, 32'd3);
    check("R3", "second frame", {16'h0, frameNum}, 32'h2);
  endtask

  task automatic testRegMap();
    logic [31:0] v;
    regWrite(3'd1, 32'h0000_1234);
    regWrite(3'd2, 32'h0000_FFFF);
    regRead(3'd1, v); check("R8", "remaining write ignored", v, 32'd3);
    regRead(3'd2, v); check("R8", "frame write ignored", v, 32'd2);
    regWrite(3'd4, 32'hFFFF_FFFF);
    regRead(3'd4, v); check("R9", "threshold masked", v, 32'h0000_7FFF);
    regWrite(3'd3, 32'hFFFF_FFFF);
    regRead(3'd3, v); check("R9", "periodic start masked", v, 32'h0000_3FFF);
    regWrite(3'd0, 32'hFFFF_FFFF);
    regRead(3'd0, v); check("R9", "interval masked", v, 32'hFFFF_3FFF);
    regRead(3'd5, v); check("R8", "unmapped reads zero", v, 32'h0);
  endtask

  task automatic testOverflow();
    regWrite(3'd0, 32'h0000_0000);
    runTicks(3);
    check("R2", "frame before fast run", {16'h0, frameNum}, 32'h2);
    sofCnt = 0; ovfCnt = 0;
    runTicks(32765);
    check("R3", "sof per frame", sofCnt, 32'd32765);
    check("R6", "no ovf below 0x8000", ovfCnt, 32'd0);
    check("R6", "at 0x7FFF", {16'h0, frameNum}, 32'h7FFF);
    check("R7", "win on at zero count", {31'h0, periodicWin}, 32'h1);
    runTicks(1);
    check("R6", "ovf on 0x8000", {30'h0, ovfPulse, sofPulse}, 32'h3);
    ovfCnt = 0;
    runTicks(32767);
    check("R6", "no ovf in upper half", ovfCnt, 32'd0);
    check("R6", "at 0xFFFF", {16'h0, frameNum}, 32'hFFFF);
    runTicks(1);
    check("R6", "ovf on wrap", {30'h0, ovfPulse, sofPulse}, 32'h3);
    check("R6", "wrapped to 0", {16'h0, frameNum}, 32'h0);
    @(negedge clk);
    check("R6", "ovf one cycle wide", {31'h0, ovfPulse}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCountDown();
    testWindow();
    testDeferredInterval();
    testToggleClear();
    testRegMap();
    testOverflow();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule